// File: doc/BRIEF.md
# Bus-Cycle Time-Slot Sequencer

This block runs on a fast logic clock and divides it down into a slower processor bus clock. Every bus cycle is split into a fixed number of equal time slots, eight by default. One enable line per slot is raised in turn, and exactly one of them is high on each fast-clock edge. Logic placed beside the processor bus uses these enables to sequence its own work. Because the slots are locked to the bus cycle, that work fits inside a single bus access and no wait states are needed.

When a bus access begins, the host announces it in slot 0 with a start flag and a direction flag. For a write, the processor's data is valid in slot 0, so the block raises a write window over the remaining slots for work that follows the write. For a read, the processor samples data at the end of the last slot, so the block raises a read window over the slots before that point. A write cycle followed directly by a read cycle therefore gives fourteen window slots, seven in each cycle.

Top module: `slot_phase_gen`

## Requirements
- R1: `phase_en` is always one-hot, and its value is `1 << slot`: bit 0 marks slot 0 and bit SLOTS-1 marks the last slot.
- R2: The slot index advances by one on every fast-clock edge and wraps from SLOTS-1 to 0, with no slot skipped or repeated.
- R3: `bus_clk` is high during slots 0 to SLOTS/2-1 and low during the remaining slots, so one bus-clock period spans SLOTS fast clocks.
- R4: When `rst` is sampled high on a clock edge, the block restarts in slot 0 with `bus_clk` high and `wr_win` low, whatever slot it was in.
- R5: If `cyc_start` and `cyc_write` are both high in slot 0, `wr_win` is high in slots 1 to SLOTS-1 of that cycle and low in slot 0.
- R6: If `cyc_start` is high and `cyc_write` is low in slot 0, `rd_win` is high in slots 0 to SLOTS-2 of that cycle and low in the last slot. In slot 0 it follows the inputs directly.
- R7: `cyc_start` is ignored in every slot other than slot 0. Neither window rises because of it.
- R8: A cycle that does not start with `cyc_start` in slot 0 has both windows low throughout, and a window never carries over into the next cycle.
- R9: A write cycle followed directly by a read cycle yields 2*(SLOTS-1) window slots over the two cycles, with no extra slot inserted between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast logic clock, SLOTS times the bus-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | Bus access begins; sampled only in slot 0 |
| cyc_write | input | 1 | Direction of the access: 1 for write, 0 for read |
| bus_clk | output | 1 | Divided clock for the processor bus |
| phase_en | output | SLOTS | One-hot slot enables |
| wr_win | output | 1 | Work window after a write strobe |
| rd_win | output | 1 | Work window before the read sample |

## Verification
The bench targets the slot boundaries. If the write window opened in slot 0, or the read window stayed open into the last slot, the count of window slots over a write-then-read pair would differ from fourteen. A start flag raised mid-cycle is held across every remaining slot, so a design that sampled it anywhere but slot 0 would open a window, and a window leaking into the next cycle would be seen in that cycle's first slots. A reset in the middle of a cycle checks that the design returns to slot 0 with the bus clock high, rather than finishing the current rotation first.

// File: rtl/slot_phase_gen.sv
module slot_phase_gen #(
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             cyc_write,
  output logic             bus_clk,
  output logic [SLOTS-1:0] phase_en,
  output logic             wr_win,
  output logic             rd_win
);
  localparam int SW   = (SLOTS > 2) ? $clog2(SLOTS) : 1;
  localparam int HIGH = SLOTS / 2;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot, slot_nx;
  logic          wr_act, rd_act;
  logic          at_first, at_last;

  assign at_first = (slot == '0);
  assign at_last  = (slot == LAST);
  assign slot_nx  = at_last ? '0 : slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= '0;
      bus_clk <= 1'b1;
      wr_act  <= 1'b0;
      rd_act  <= 1'b0;
    end else begin
      slot    <= slot_nx;
      bus_clk <= (32'(slot_nx) < HIGH);
      if (at_first) begin
        wr_act <= cyc_start &  cyc_write;
        rd_act <= cyc_start & ~cyc_write;
      end else if (at_last) begin
        wr_act <= 1'b0;
        rd_act <= 1'b0;
      end
    end
  end

  assign phase_en = {{(SLOTS-1){1'b0}}, 1'b1} << slot;
  assign wr_win   = wr_act & ~at_first;
  assign rd_win   = at_first ? (cyc_start & ~cyc_write) : (rd_act & ~at_last);

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_en) == 1);

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    !phase_en[SLOTS-1] |=> phase_en == ($past(phase_en) << 1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    phase_en[SLOTS-1] |=> phase_en[0]);

  p_busclk_r3: assert property (@(posedge clk) disable iff (rst)
    bus_clk == (phase_en[HIGH-1:0] != '0));

  p_reset_r4: assert property (@(posedge clk)
    rst |=> (phase_en[0] && bus_clk && !wr_win));

  p_wr_slot0_r5: assert property (@(posedge clk) disable iff (rst)
    wr_win |-> !phase_en[0]);

  p_rd_last_r6: assert property (@(posedge clk) disable iff (rst)
    rd_win |-> !phase_en[SLOTS-1]);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_win && rd_win));
endmodule

// File: tb/slot_phase_gen_test.sv
module slot_phase_gen_test;
  localparam int SLOTS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic cyc_write = 1'b0;
  logic bus_clk, wr_win, rd_win;
  logic [SLOTS-1:0] phase_en;

  int checks = 0;
  int errors = 0;

  slot_phase_gen #(.SLOTS(SLOTS)) uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_write(cyc_write),
    .bus_clk(bus_clk), .phase_en(phase_en), .wr_win(wr_win), .rd_win(rd_win)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic go_slot0();
    @(negedge clk);
    while (!phase_en[0]) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R4 reset phase", phase_en, 1);
    check("R4 reset bus_clk", bus_clk, 1);
    check("R4 reset wr_win", wr_win, 0);
    check("R4 reset rd_win", rd_win, 0);
  endtask

  task automatic t_rotation();
    for (int i = 0; i < 3 * SLOTS; i++) begin
      check("R1 R2 phase", phase_en, 1 << (i % SLOTS));
      check("R3 bus_clk", bus_clk, ((i % SLOTS) < SLOTS / 2) ? 1 : 0);
      check("R8 idle windows", {wr_win, rd_win}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_write();
    go_slot0();
    cyc_start = 1'b1; cyc_write = 1'b1;
    #1;
    check("R5 wr slot0", wr_win, 0);
    check("R6 no rd on write", rd_win, 0);
    @(negedge clk);
    cyc_start = 1'b0; cyc_write = 1'b0;
    for (int s = 1; s < SLOTS; s++) begin
      check("R5 wr window", wr_win, 1);
      check("R5 rd stays low", rd_win, 0);
      @(negedge clk);
    end
    check("R8 wr no carry", wr_win, 0);
  endtask

  task automatic t_read();
    go_slot0();
    cyc_start = 1'b1; cyc_write = 1'b0;
    #1;
    check("R6 rd slot0", rd_win, 1);
    @(negedge clk);
    cyc_start = 1'b0;
    for (int s = 1; s < SLOTS; s++) begin
      check("R6 rd window", rd_win, (s < SLOTS - 1) ? 1 : 0);
      check("R6 wr stays low", wr_win, 0);
      @(negedge clk);
    end
    check("R8 rd no carry", rd_win, 0);
  endtask

  task automatic t_ignore_midcycle();
    go_slot0();
    @(negedge clk);
    cyc_start = 1'b1; cyc_write = 1'b1;
    for (int s = 1; s < SLOTS; s++) begin
      check("R7 mid start ignored", {wr_win, rd_win}, 0);
      @(negedge clk);
    end
    cyc_start = 1'b0; cyc_write = 1'b0;
    #1;
    check("R7 slot0 after ignore", {wr_win, rd_win}, 0);
    @(negedge clk);
    check("R7 no late window", {wr_win, rd_win}, 0);
  endtask

  task automatic t_write_read_pair();
    int total = 0;
    go_slot0();
    cyc_start = 1'b1; cyc_write = 1'b1;
    for (int i = 0; i < 2 * SLOTS; i++) begin
      #1;
      total += int'(wr_win) + int'(rd_win);
      @(negedge clk);
      if (i == 0) cyc_start = 1'b0;
      if (i == SLOTS - 1) begin cyc_start = 1'b1; cyc_write = 1'b0; end
      if (i == SLOTS) cyc_start = 1'b0;
    end
    check("R9 window slots", total, 2 * (SLOTS - 1));
  endtask

  task automatic t_midcycle_reset();
    go_slot0();
    cyc_start = 1'b1; cyc_write = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; cyc_write = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R4 pre-reset slot", phase_en, 1 << 3);
    rst = 1'b1;
    @(negedge clk);
    check("R4 mid reset phase", phase_en, 1);
    check("R4 mid reset bus_clk", bus_clk, 1);
    check("R4 mid reset wr_win", wr_win, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset", phase_en, 2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_rotation();
    t_write();
    t_read();
    t_ignore_midcycle();
    t_write_read_pair();
    t_midcycle_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule